// File: doc/BRIEF.md
# Interleaved Four-Bank Data Memory

This block is the on-chip data store behind a core that issues two load/store operations per cycle. Storage is split into four single-ported banks, each 16 bits wide. Consecutive byte addresses are dealt out two at a time to bank 0, 1, 2 and 3, then wrap, so each eight-byte stretch of address space forms one row across all four banks. Byte, halfword and 32-bit word accesses are supported. A word occupies a pair of neighbouring banks within a single row.

Each cycle, both ports present a request. When their bank sets are disjoint, both are carried out at once. When they share a bank, port 0 is served in the request cycle. Port 1's request is captured internally and performed in the following cycle. During that following cycle the `stall` output is high, and the core must treat it as a frozen cycle. Loads return data one cycle after their access is carried out. Misaligned requests are refused and reported through an error flag.

Top module: `ilv_data_mem`

## Requirements
- R1: Byte address `a` lives in bank `a[2:1]`, byte lane `a[0]` of that bank (lane 0 = bits 7:0), row `a[ROW_W+2:3]`; bytes stored by one access size are readable by any other size at the same address.
- R2: A word access (size code 2) stores `wdata[8i+7:8i]` at byte `a+i` for i = 0..3, occupying bank `a[2:1]` and bank `a[2:1]+1` in the same row.
- R3: Size code 0 is a byte and code 1 a halfword; a byte store writes only `wdata[7:0]` to the addressed byte and a halfword store only `wdata[15:0]` to its two bytes, leaving every other byte unchanged.
- R4: Loads return the value right-aligned in `rdata` with zeros in all bits above the access size.
- R5: For a load that is carried out in a cycle, `rvalid` is high and `rdata` holds the data in the next cycle; `rdata` is zero whenever `rvalid` is low, and stores never raise `rvalid`.
- R6: Two aligned requests that touch disjoint banks are both carried out in the same cycle, and `stall` stays low.
- R7: Two aligned requests that share any bank cause port 0 to be carried out in the request cycle; `stall` is high for exactly the next cycle, in which port 1's captured request is carried out, so a port-1 load delivers its data one cycle after the stall.
- R8: When both ports store to the same byte in one cycle, the byte ends up holding port 1's value.
- R9: Requests presented on either port while `stall` is high are ignored and change no memory.
- R10: A word with `a[1:0]` not zero, a halfword with `a[0]` set, or size code 3 is not performed, raises that port's `err` for one cycle in the next cycle with `rvalid` low, and never takes part in a bank clash.
- R11: While `rst_n` is low at a clock edge, `stall`, both `rvalid`, both `err` and both `rdata` become zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| p0_req | input | 1 | Port 0 request valid |
| p0_we | input | 1 | Port 0 store (1) or load (0) |
| p0_size | input | 2 | Port 0 size: 0 byte, 1 half, 2 word, 3 reserved |
| p0_addr | input | ROW_W+3 | Port 0 byte address |
| p0_wdata | input | 32 | Port 0 store data, right-aligned |
| p0_rdata | output | 32 | Port 0 load data |
| p0_rvalid | output | 1 | Port 0 load data valid |
| p0_err | output | 1 | Port 0 misaligned request refused |
| p1_req | input | 1 | Port 1 request valid |
| p1_we | input | 1 | Port 1 store (1) or load (0) |
| p1_size | input | 2 | Port 1 size code |
| p1_addr | input | ROW_W+3 | Port 1 byte address |
| p1_wdata | input | 32 | Port 1 store data, right-aligned |
| p1_rdata | output | 32 | Port 1 load data |
| p1_rvalid | output | 1 | Port 1 load data valid |
| p1_err | output | 1 | Port 1 misaligned request refused |
| stall | output | 1 | Freeze cycle: port 1's deferred access is carried out |

## Verification
A wrong bank or lane decode does not show up as a bad load of the same location at the same size. It only appears when data is written at one size and read back at another. For that reason, every layout check crosses sizes, and each one reports within two cycles of the read. A bad clash decision shows directly at the ports. Either `stall` rises in the cycle after a request pair that should have run in parallel, or it fails to rise after a pair that shares a bank. In the second case the clash also leaves corrupted bytes behind, which later loads expose. A deferred request that is lost or replayed from the live inputs shows up when the stall cycle's discarded stimulus is later read back.

// File: rtl/dmem_pkg.sv
// Shared types and geometry for the interleaved data memory.
// Assumes four banks of two bytes each; a word spans two banks.
package dmem_pkg;
    localparam int BANKS  = 4;
    localparam int BANK_W = $clog2(BANKS);
    localparam int OFS_W  = BANK_W + 1;   // byte offset bits within one row

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // What a load needs to remember to assemble its data one cycle later.
    typedef struct packed {
        logic              load;
        logic [BANK_W-1:0] bank;
        logic              lane;
        acc_size_e         size;
    } rd_ctx_t;
endpackage

// File: rtl/dmem_lane_map.sv
// Decodes one port's request into per-bank enables, byte enables, write data and row.
// Assumes the caller already chose which request (live or captured) is presented.
module dmem_lane_map
    import dmem_pkg::*;
#(
    parameter int ROW_W = 8,
    localparam int AW = ROW_W + OFS_W
) (
    input  logic                      req,
    input  logic                      we,
    input  acc_size_e                 size,
    input  logic [AW-1:0]             addr,
    input  logic [31:0]               wdata,
    output logic                      ok,
    output logic                      bad,
    output logic [BANKS-1:0]          mask,
    output logic [BANKS-1:0][1:0]     be,
    output logic [BANKS-1:0][15:0]    wd,
    output logic [ROW_W-1:0]          row,
    output rd_ctx_t                   ctx
);
    logic [BANK_W-1:0] bidx;
    logic [BANK_W-1:0] nidx;
    logic              aligned;
    logic [BANKS-1:0]  raw_mask;

    // Map size and address onto banks and byte lanes, and judge alignment.
    always_comb begin
        bidx     = addr[OFS_W-1:1];
        nidx     = bidx + BANK_W'(1);
        aligned  = 1'b0;
        raw_mask = '0;
        be       = '0;
        wd       = '0;
        unique case (size)
            SZ_BYTE: begin
                aligned              = 1'b1;
                raw_mask[bidx]       = 1'b1;
                be[bidx][addr[0]]    = 1'b1;
                wd[bidx]             = {2{wdata[7:0]}};
            end
            SZ_HALF: begin
                aligned              = ~addr[0];
                raw_mask[bidx]       = 1'b1;
                be[bidx]             = 2'b11;
                wd[bidx]             = wdata[15:0];
            end
            SZ_WORD: begin
                aligned              = (addr[1:0] == 2'b00);
                raw_mask[bidx]       = 1'b1;
                raw_mask[nidx]       = 1'b1;
                be[bidx]             = 2'b11;
                be[nidx]             = 2'b11;
                wd[bidx]             = wdata[15:0];
                wd[nidx]             = wdata[31:16];
            end
            default: aligned = 1'b0;
        endcase
    end

    // Qualify the request and pack what the load path needs later.
    always_comb begin
        ok       = req & aligned;
        bad      = req & ~aligned;
        mask     = ok ? raw_mask : '0;
        row      = addr[AW-1:OFS_W];
        ctx.load = ok & ~we;
        ctx.bank = bidx;
        ctx.lane = addr[0];
        ctx.size = size;
    end
endmodule

// File: rtl/dmem_bank.sv
// One single-ported 16-bit bank with two byte enables and a registered read.
// Assumes at most one access per cycle; contents are not reset.
module dmem_bank #(
    parameter int ROW_W = 8,
    localparam int DEPTH = 1 << ROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             we,
    input  logic [1:0]       be,
    input  logic [ROW_W-1:0] row,
    input  logic [15:0]      wd,
    output logic [15:0]      q
);
    logic [15:0] mem [DEPTH];

    // Byte-lane write into the storage array.
    always_ff @(posedge clk) begin
        if (en && we) begin
            if (be[0]) mem[row][7:0]  <= wd[7:0];
            if (be[1]) mem[row][15:8] <= wd[15:8];
        end
    end

    // Registered read; output holds until the next read of this bank.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (en && !we)
            q <= mem[row];
    end
endmodule

// File: rtl/dmem_read_align.sv
// Builds a port's right-aligned, zero-extended load value from the bank outputs.
// Assumes the context was captured in the same cycle the banks were read.
module dmem_read_align
    import dmem_pkg::*;
(
    input  rd_ctx_t                ctx,
    input  logic [BANKS-1:0][15:0] bank_q,
    output logic [31:0]            data
);
    logic [BANK_W-1:0] nidx;
    logic [15:0]       lo;

    // Select lane(s) by size, zero elsewhere and when no load is due.
    always_comb begin
        nidx = ctx.bank + BANK_W'(1);
        lo   = bank_q[ctx.bank];
        data = '0;
        if (ctx.load) begin
            unique case (ctx.size)
                SZ_BYTE: data = {24'd0, (ctx.lane ? lo[15:8] : lo[7:0])};
                SZ_HALF: data = {16'd0, lo};
                SZ_WORD: data = {bank_q[nidx], lo};
                default: data = '0;
            endcase
        end
    end
endmodule

// File: rtl/ilv_data_mem.sv
// Two-port data memory over four interleaved single-ported banks.
// On a bank clash port 0 goes first; port 1 is captured and replayed in a
// one-cycle stall during which both live request inputs are ignored.
module ilv_data_mem
    import dmem_pkg::*;
#(
    parameter int ROW_W = 8,
    localparam int AW = ROW_W + OFS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          p0_req,
    input  logic          p0_we,
    input  logic [1:0]    p0_size,
    input  logic [AW-1:0] p0_addr,
    input  logic [31:0]   p0_wdata,
    output logic [31:0]   p0_rdata,
    output logic          p0_rvalid,
    output logic          p0_err,
    input  logic          p1_req,
    input  logic          p1_we,
    input  logic [1:0]    p1_size,
    input  logic [AW-1:0] p1_addr,
    input  logic [31:0]   p1_wdata,
    output logic [31:0]   p1_rdata,
    output logic          p1_rvalid,
    output logic          p1_err,
    output logic          stall
);
    // Captured port-1 request for the stall cycle.
    logic          stall_q;
    logic          h_we;
    acc_size_e     h_size;
    logic [AW-1:0] h_addr;
    logic [31:0]   h_wdata;

    // Requests actually presented to the decoders this cycle.
    logic          e0_req, e1_req, e1_we;
    acc_size_e     e1_size;
    logic [AW-1:0] e1_addr;
    logic [31:0]   e1_wdata;

    logic                   ok0, ok1, bad0, bad1;
    logic [BANKS-1:0]       m0, m1;
    logic [BANKS-1:0][1:0]  be0, be1;
    logic [BANKS-1:0][15:0] wd0, wd1;
    logic [ROW_W-1:0]       row0, row1;
    rd_ctx_t                c0, c1, ctx0_q, ctx1_q;
    logic                   clash, go1;
    logic                   err0_q, err1_q;

    logic [BANKS-1:0]             b_en, b_we;
    logic [BANKS-1:0][1:0]        b_be;
    logic [BANKS-1:0][ROW_W-1:0]  b_row;
    logic [BANKS-1:0][15:0]       b_wd;
    logic [BANKS-1:0][15:0]       b_q;

    // Choose live inputs normally, the captured port-1 request during a stall.
    always_comb begin
        e0_req   = p0_req & ~stall_q;
        e1_req   = stall_q ? 1'b1    : p1_req;
        e1_we    = stall_q ? h_we    : p1_we;
        e1_size  = stall_q ? h_size  : acc_size_e'(p1_size);
        e1_addr  = stall_q ? h_addr  : p1_addr;
        e1_wdata = stall_q ? h_wdata : p1_wdata;
    end

    dmem_lane_map #(.ROW_W(ROW_W)) u_map0 (
        .req(e0_req), .we(p0_we), .size(acc_size_e'(p0_size)), .addr(p0_addr),
        .wdata(p0_wdata), .ok(ok0), .bad(bad0), .mask(m0), .be(be0), .wd(wd0),
        .row(row0), .ctx(c0)
    );

    dmem_lane_map #(.ROW_W(ROW_W)) u_map1 (
        .req(e1_req), .we(e1_we), .size(e1_size), .addr(e1_addr),
        .wdata(e1_wdata), .ok(ok1), .bad(bad1), .mask(m1), .be(be1), .wd(wd1),
        .row(row1), .ctx(c1)
    );

    // Detect a shared bank between two fresh aligned requests.
    always_comb begin
        clash = ~stall_q & ok0 & ok1 & (|(m0 & m1));
        go1   = ok1 & ~clash;
    end

    // Steer each bank to the port that owns it this cycle.
    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            b_en[b] = (ok0 & m0[b]) | (go1 & m1[b]);
            if (go1 && m1[b]) begin
                b_we[b]  = e1_we;
                b_be[b]  = be1[b];
                b_row[b] = row1;
                b_wd[b]  = wd1[b];
            end else begin
                b_we[b]  = p0_we;
                b_be[b]  = be0[b];
                b_row[b] = row0;
                b_wd[b]  = wd0[b];
            end
        end
    end

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        dmem_bank #(.ROW_W(ROW_W)) u_bank (
            .clk(clk), .rst_n(rst_n), .en(b_en[g]), .we(b_we[g]), .be(b_be[g]),
            .row(b_row[g]), .wd(b_wd[g]), .q(b_q[g])
        );
    end

    // Stall flag and capture of the deferred port-1 request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q <= 1'b0;
            h_we    <= 1'b0;
            h_size  <= SZ_BYTE;
            h_addr  <= '0;
            h_wdata <= '0;
        end else begin
            stall_q <= clash;
            if (clash) begin
                h_we    <= p1_we;
                h_size  <= acc_size_e'(p1_size);
                h_addr  <= p1_addr;
                h_wdata <= p1_wdata;
            end
        end
    end

    // Load contexts and error pulses, one cycle behind the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx0_q <= '0;
            ctx1_q <= '0;
            err0_q <= 1'b0;
            err1_q <= 1'b0;
        end else begin
            ctx0_q      <= c0;
            ctx1_q      <= c1;
            ctx1_q.load <= c1.load & go1;
            err0_q      <= bad0;
            err1_q      <= bad1;
        end
    end

    dmem_read_align u_align0 (.ctx(ctx0_q), .bank_q(b_q), .data(p0_rdata));
    dmem_read_align u_align1 (.ctx(ctx1_q), .bank_q(b_q), .data(p1_rdata));

    assign p0_rvalid = ctx0_q.load;
    assign p1_rvalid = ctx1_q.load;
    assign p0_err    = err0_q;
    assign p1_err    = err1_q;
    assign stall     = stall_q;

    AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) stall |=> !stall); // R7
    AST_STALL_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n) $rose(stall) |-> $past(p0_req && p1_req)); // R7
    AST_DEFERRED_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (stall && !h_we) |=> p1_rvalid); // R7
    AST_ERR0_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n) p0_err |-> !p0_rvalid); // R10
    AST_ERR1_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n) p1_err |-> !p1_rvalid); // R10
    AST_WORD_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && p0_req && !p0_we && p0_size == 2'd2 && p0_addr[1:0] == 2'b00) |=> p0_rvalid); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !p0_req) |=> (!p0_rvalid && !p0_err)); // R5
endmodule

// File: tb/ilv_data_mem_test.sv
module ilv_data_mem_test;
    localparam int ROW_W = 8;
    localparam int AW    = ROW_W + 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          p0_req, p0_we, p1_req, p1_we;
    logic [1:0]    p0_size, p1_size;
    logic [AW-1:0] p0_addr, p1_addr;
    logic [31:0]   p0_wdata, p1_wdata;
    logic [31:0]   p0_rdata, p1_rdata;
    logic          p0_rvalid, p1_rvalid, p0_err, p1_err, stall;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    logic [7:0] mm [0:(1<<AW)-1];

    always #5 clk = ~clk;

    ilv_data_mem #(.ROW_W(ROW_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .p0_req(p0_req), .p0_we(p0_we), .p0_size(p0_size), .p0_addr(p0_addr),
        .p0_wdata(p0_wdata), .p0_rdata(p0_rdata), .p0_rvalid(p0_rvalid), .p0_err(p0_err),
        .p1_req(p1_req), .p1_we(p1_we), .p1_size(p1_size), .p1_addr(p1_addr),
        .p1_wdata(p1_wdata), .p1_rdata(p1_rdata), .p1_rvalid(p1_rvalid), .p1_err(p1_err),
        .stall(stall)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    task automatic model_wr(input logic [AW-1:0] a, input logic [1:0] sz, input logic [31:0] d);
        for (int i = 0; i < nbytes(sz); i++) mm[a + AW'(i)] = d[8*i +: 8];
    endtask

    function automatic logic [31:0] model_rd(input logic [AW-1:0] a, input logic [1:0] sz);
        logic [31:0] r = '0;
        for (int i = 0; i < nbytes(sz); i++) r[8*i +: 8] = mm[a + AW'(i)];
        return r;
    endfunction

    task automatic put0(input bit rq, input bit w, input logic [1:0] sz, input logic [AW-1:0] a, input logic [31:0] d);
        p0_req = rq; p0_we = w; p0_size = sz; p0_addr = a; p0_wdata = d;
    endtask

    task automatic put1(input bit rq, input bit w, input logic [1:0] sz, input logic [AW-1:0] a, input logic [31:0] d);
        p1_req = rq; p1_we = w; p1_size = sz; p1_addr = a; p1_wdata = d;
    endtask

    task automatic idle();
        put0(0, 0, 2'd0, '0, '0);
        put1(0, 0, 2'd0, '0, '0);
    endtask

    // Single store through port 0; model updated.
    task automatic wr(input logic [AW-1:0] a, input logic [1:0] sz, input logic [31:0] d);
        put0(1, 1, sz, a, d);
        @(negedge clk);
        idle();
        model_wr(a, sz, d);
    endtask

    // Single load through port 1, checked against the model.
    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [1:0] sz);
        put1(1, 0, sz, a, '0);
        @(negedge clk);
        chk(req, {31'd0, p1_rvalid}, 32'd1);
        chk(req, p1_rdata, model_rd(a, sz));
        idle();
    endtask

    task automatic t_reset();
        chk("R11 stall", {31'd0, stall}, 32'd0);
        chk("R11 rvalid", {30'd0, p0_rvalid, p1_rvalid}, 32'd0);
        chk("R11 err", {30'd0, p0_err, p1_err}, 32'd0);
        chk("R11 rdata0", p0_rdata, 32'd0);
        chk("R11 rdata1", p1_rdata, 32'd0);
    endtask

    task automatic t_layout();
        wr(11'h010, 2'd2, 32'hA1B2C3D4);
        for (int i = 0; i < 4; i++) rd_chk("R1 R2 byte of word", 11'h010 + AW'(i), 2'd0);
        wr(11'h01C, 2'd2, 32'h0F1E2D3C);          // banks 2 and 3
        rd_chk("R2 low half", 11'h01C, 2'd1);
        rd_chk("R2 high half", 11'h01E, 2'd1);
        rd_chk("R1 word", 11'h010, 2'd2);
    endtask

    task automatic t_partial();
        wr(11'h020, 2'd2, 32'h11223344);
        wr(11'h022, 2'd0, 32'hFFFFFFEE);
        wr(11'h020, 2'd1, 32'hABCD5566);
        put1(1, 0, 2'd2, 11'h020, '0);
        @(negedge clk);
        chk("R3 merged word", p1_rdata, 32'h11EE5566);
        idle();
        put1(1, 0, 2'd0, 11'h023, '0);
        @(negedge clk);
        chk("R4 byte zero-extend", p1_rdata, 32'h00000011);
        idle();
        put1(1, 1, 2'd0, 11'h020, 32'h000000AA);   // store: no rvalid
        @(negedge clk);
        chk("R5 store no rvalid", {31'd0, p1_rvalid}, 32'd0);
        chk("R5 rdata zero idle", p1_rdata, 32'd0);
        idle();
        model_wr(11'h020, 2'd0, 32'hAA);
        rd_chk("R3 byte store", 11'h020, 2'd2);
    endtask

    task automatic t_parallel();
        wr(11'h030, 2'd2, 32'h87654321);
        wr(11'h040, 2'd2, 32'hCAFEF00D);
        wr(11'h044, 2'd2, 32'h600DD00D);
        put0(1, 0, 2'd0, 11'h031, '0);             // bank 0
        put1(1, 0, 2'd1, 11'h032, '0);             // bank 1
        @(negedge clk);
        chk("R6 no stall", {31'd0, stall}, 32'd0);
        chk("R6 p0 data", p0_rdata, 32'h00000043);
        chk("R6 p1 data", p1_rdata, 32'h00008765);
        put0(1, 0, 2'd2, 11'h040, '0);             // banks 0,1
        put1(1, 0, 2'd2, 11'h044, '0);             // banks 2,3
        @(negedge clk);
        chk("R6 word pair no stall", {31'd0, stall}, 32'd0);
        chk("R6 word p0", p0_rdata, 32'hCAFEF00D);
        chk("R6 word p1", p1_rdata, 32'h600DD00D);
        idle();
        @(negedge clk);
    endtask

    task automatic t_conflict();
        wr(11'h050, 2'd2, 32'h0BAD1234);
        wr(11'h058, 2'd2, 32'h5EED7788);
        put0(1, 0, 2'd1, 11'h050, '0);
        put1(1, 0, 2'd1, 11'h058, '0);
        @(negedge clk);
        idle();
        chk("R7 stall raised", {31'd0, stall}, 32'd1);
        chk("R7 p0 first valid", {31'd0, p0_rvalid}, 32'd1);
        chk("R7 p0 first data", p0_rdata, 32'h00001234);
        chk("R7 p1 not yet", {31'd0, p1_rvalid}, 32'd0);
        @(negedge clk);
        chk("R7 stall one cycle", {31'd0, stall}, 32'd0);
        chk("R7 p1 deferred valid", {31'd0, p1_rvalid}, 32'd1);
        chk("R7 p1 deferred data", p1_rdata, 32'h00007788);
        put0(1, 1, 2'd2, 11'h060, 32'h01020304);   // banks 0,1
        put1(1, 0, 2'd0, 11'h063, '0);             // bank 1
        model_wr(11'h060, 2'd2, 32'h01020304);
        @(negedge clk);
        idle();
        chk("R2 R7 word-byte clash", {31'd0, stall}, 32'd1);
        @(negedge clk);
        chk("R7 p1 after word store", p1_rdata, 32'h00000001);
    endtask

    task automatic t_same_byte();
        wr(11'h070, 2'd2, 32'h0);
        put0(1, 1, 2'd0, 11'h071, 32'h12);
        put1(1, 1, 2'd0, 11'h071, 32'h34);
        @(negedge clk);
        idle();
        chk("R8 clash stall", {31'd0, stall}, 32'd1);
        @(negedge clk);
        model_wr(11'h071, 2'd0, 32'h34);
        rd_chk("R8 port1 wins", 11'h070, 2'd2);
    endtask

    task automatic t_ignore();
        wr(11'h090, 2'd2, 32'h01020304);
        wr(11'h094, 2'd2, 32'h05060708);
        put0(1, 1, 2'd1, 11'h080, 32'hAAAA);
        put1(1, 1, 2'd1, 11'h088, 32'hBBBB);
        @(negedge clk);
        chk("R9 in stall", {31'd0, stall}, 32'd1);
        put0(1, 1, 2'd2, 11'h090, 32'hDEADBEEF);
        put1(1, 1, 2'd0, 11'h094, 32'h000000FF);
        @(negedge clk);
        idle();
        model_wr(11'h080, 2'd1, 32'hAAAA);
        model_wr(11'h088, 2'd1, 32'hBBBB);
        rd_chk("R9 p0 ignored", 11'h090, 2'd2);
        rd_chk("R9 p1 ignored", 11'h094, 2'd2);
        rd_chk("R7 p1 captured store", 11'h088, 2'd1);
        rd_chk("R7 p0 store", 11'h080, 2'd1);
    endtask

    task automatic t_misalign();
        wr(11'h0A0, 2'd2, 32'h13579BDF);
        put0(1, 1, 2'd2, 11'h0A2, 32'hFFFFFFFF);
        put1(1, 0, 2'd1, 11'h0A5, '0);
        @(negedge clk);
        idle();
        chk("R10 err both", {30'd0, p0_err, p1_err}, 32'd3);
        chk("R10 no rvalid", {30'd0, p0_rvalid, p1_rvalid}, 32'd0);
        chk("R10 no stall", {31'd0, stall}, 32'd0);
        @(negedge clk);
        chk("R10 err one cycle", {30'd0, p0_err, p1_err}, 32'd0);
        rd_chk("R10 no write", 11'h0A0, 2'd2);
        put0(1, 0, 2'd2, 11'h0A0, '0);             // banks 0,1
        put1(1, 1, 2'd1, 11'h0A1, 32'h0);          // bank 0, misaligned
        @(negedge clk);
        idle();
        chk("R10 no clash", {31'd0, stall}, 32'd0);
        chk("R10 p0 served", p0_rdata, 32'h13579BDF);
        chk("R10 p1 err", {31'd0, p1_err}, 32'd1);
        put0(1, 1, 2'd3, 11'h0A0, 32'h0);          // reserved size
        @(negedge clk);
        idle();
        chk("R10 reserved size err", {31'd0, p0_err}, 32'd1);
        rd_chk("R10 reserved no write", 11'h0A0, 2'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_layout();
        t_partial();
        t_parallel();
        t_conflict();
        t_same_byte();
        t_ignore();
        t_misalign();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule